// File: doc/BRIEF.md
# Paged GPIO Register File

This block is a byte-wide register file for a 48-line parallel I/O controller. The lines form six 8-bit ports. A host reaches the block over a simple synchronous bus with a 4-bit byte offset. The block decodes an 11-byte window. Port offsets read the live, synchronized pin levels and write the port's output latch. A latch bit of 1 drives its line, and a latch bit of 0 releases the line so that it can serve as an input.

A single control byte sets the register page in its two upper bits. Its six lower bits are write locks, one for each port. Three offsets at the top of the window form a paged window onto per-port interrupt registers for the first three ports: edge polarity, interrupt enable, and interrupt identification. The block holds the polarity and enable registers and hands them to a companion edge-detection unit. That unit returns per-line pending flags. The block presents those flags on the identification page, and their per-port OR appears as a summary byte.

Top module: `pagedGpioRegs`

## Requirements
- R1: After reset all output latches, polarity and enable registers, the page/lock byte and the read data are zero.
- R2: A write to offset p (0..5) loads the 8-bit output latch of port p when that port is unlocked, and it shows on latchOut[8p+7:8p] after the write edge.
- R3: While bit p of the page/lock byte (offset 7, bits 5:0) is 1, writes to port p leave its latch unchanged. Writing 0 to those bits unlocks the ports again.
- R4: A read of offset p (0..5) returns the levels of pinIn[8p+7:8p] after a two-flop synchronizer. A pin change is therefore not seen by a read issued on the next cycle, and it is seen by a read issued three cycles after the change.
- R5: The page is bits 7:6 of offset 7, and a read of offset 7 returns the stored byte.
- R6: With page 1 selected, offsets 8, 9 and 10 read and write the edge polarity registers of ports 0, 1 and 2, and these registers drive polOut.
- R7: With page 2 selected, offsets 8, 9 and 10 read and write the interrupt enable registers of ports 0, 1 and 2, and these registers drive enOut.
- R8: With page 3 selected, offsets 8, 9 and 10 read idIn for ports 0, 1 and 2. Writes there change no register.
- R9: With page 0 selected, offsets 8 to 10 read as zero and ignore writes.
- R10: A read of offset 6 returns, in bit p (p = 0..2), the OR of the eight idIn flags of port p. Bits 7:3 read as zero.
- R11: Offsets 11 to 15 read as zero and ignore writes.
- R12: Read data is registered. It appears on busRdata one cycle after a read request and holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| pinIn | input | 48 | Asynchronous pin levels, 8 per port |
| idIn | input | 24 | Pending flags from the edge unit, ports 0..2 |
| latchOut | output | 48 | Output latches, 8 per port |
| polOut | output | 24 | Edge polarity registers, ports 0..2 |
| enOut | output | 24 | Interrupt enable registers, ports 0..2 |

## Verification
The properties assume that the bus inputs are known at every sampled edge and that busSel stays low during reset. They also assume that idIn comes from logic in the same clock domain, so no synchronizer is modelled on it. The stimulus drives all bus and pin inputs on falling edges and keeps busSel low while reset is asserted. Before any model-compared port read it leaves pins and flags unchanged for at least three cycles. The only exception is the directed latency check of R4.

// File: rtl/gpioPkg.sv
package gpioPkg;
  localparam int GP_WIDTH     = 8;
  localparam int GP_PORTS     = 6;
  localparam int GP_IRQ_PORTS = 3;
  localparam int GP_ADDR_W    = 4;
  localparam int GP_SYNC      = 2;
  localparam int GP_IDX_W     = $clog2(GP_PORTS);

  localparam logic [1:0] PG_OFF = 2'd0;
  localparam logic [1:0] PG_POL = 2'd1;
  localparam logic [1:0] PG_EN  = 2'd2;
  localparam logic [1:0] PG_ID  = 2'd3;

  typedef enum logic [2:0] {
    RD_ZERO, RD_PIN, RD_SUMMARY, RD_PAGE, RD_POL, RD_EN, RD_ID
  } rdSel_e;

  // Strobes from decode to the register datapath
  typedef struct packed {
    logic [GP_PORTS-1:0]     portWr;
    logic                    pageWr;
    logic [GP_IRQ_PORTS-1:0] polWr;
    logic [GP_IRQ_PORTS-1:0] enWr;
    logic                    rdEn;
    rdSel_e                  rdSel;
    logic [GP_IDX_W-1:0]     rdIdx;
  } strobe_t;
endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPkg::*;
#(
  parameter int PORTS     = GP_PORTS,
  parameter int IRQ_PORTS = GP_IRQ_PORTS,
  parameter int ADDR_W    = GP_ADDR_W
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        page,
  output strobe_t           strb
);
  localparam int IDX_W = GP_IDX_W;
  localparam logic [ADDR_W-1:0] SUM_OFF  = ADDR_W'(PORTS);
  localparam logic [ADDR_W-1:0] PAGE_OFF = ADDR_W'(PORTS + 1);
  localparam logic [ADDR_W-1:0] WIN_OFF  = ADDR_W'(PORTS + 2);
  localparam logic [ADDR_W-1:0] WIN_END  = ADDR_W'(PORTS + 2 + IRQ_PORTS);

  logic wrReq, rdReq;
  logic [ADDR_W-1:0] winIdx;

  assign wrReq  = busSel & busWe;
  assign rdReq  = busSel & ~busWe;
  assign winIdx = busAddr - WIN_OFF;

  always_comb begin
    strb       = '0;
    strb.rdEn  = rdReq;
    strb.rdSel = RD_ZERO;
    if (busAddr < SUM_OFF) begin
      strb.rdSel = RD_PIN;
      for (int i = 0; i < PORTS; i++) begin
        if (busAddr == ADDR_W'(i)) begin
          strb.portWr[i] = wrReq;
          strb.rdIdx     = IDX_W'(i);
        end
      end
    end else if (busAddr == SUM_OFF) begin
      strb.rdSel = RD_SUMMARY;
    end else if (busAddr == PAGE_OFF) begin
      strb.rdSel  = RD_PAGE;
      strb.pageWr = wrReq;
    end else if (busAddr < WIN_END) begin
      for (int i = 0; i < IRQ_PORTS; i++) begin
        if (winIdx == ADDR_W'(i)) begin
          strb.rdIdx = IDX_W'(i);
          case (page)
            PG_POL: begin strb.rdSel = RD_POL; strb.polWr[i] = wrReq; end
            PG_EN:  begin strb.rdSel = RD_EN;  strb.enWr[i]  = wrReq; end
            PG_ID:  strb.rdSel = RD_ID;
            default: strb.rdSel = RD_ZERO;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPkg::*;
#(
  parameter int PORTS     = GP_PORTS,
  parameter int IRQ_PORTS = GP_IRQ_PORTS,
  parameter int WIDTH     = GP_WIDTH,
  parameter int SYNC      = GP_SYNC
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [WIDTH-1:0]           wdata,
  input  logic [PORTS*WIDTH-1:0]     pinIn,
  input  logic [IRQ_PORTS*WIDTH-1:0] idIn,
  output logic [PORTS*WIDTH-1:0]     latchOut,
  output logic [IRQ_PORTS*WIDTH-1:0] polOut,
  output logic [IRQ_PORTS*WIDTH-1:0] enOut,
  output logic [WIDTH-1:0]           pageLock,
  output logic [WIDTH-1:0]           rdata
);
  localparam int IDX_W = GP_IDX_W;

  logic [SYNC-1:0][PORTS*WIDTH-1:0] syncQ;
  logic [PORTS-1:0][WIDTH-1:0]      pinSync;
  logic [PORTS-1:0][WIDTH-1:0]      latchQ;
  logic [IRQ_PORTS-1:0][WIDTH-1:0]  polQ, enQ, idArr;
  logic [WIDTH-1:0]                 pageLockQ, rdataQ, rdNext;
  logic [IRQ_PORTS-1:0]             summary;

  // Pin synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC-2:0], pinIn};
  end
  assign pinSync = syncQ[SYNC-1];

  always_ff @(posedge clk) begin
    if (!rstN)            pageLockQ <= '0;
    else if (strb.pageWr) pageLockQ <= wdata;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rstN)                                latchQ[p] <= '0;
      else if (strb.portWr[p] && !pageLockQ[p]) latchQ[p] <= wdata;
    end
  end

  for (genvar q = 0; q < IRQ_PORTS; q++) begin : g_irqReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        polQ[q] <= '0;
        enQ[q]  <= '0;
      end else begin
        if (strb.polWr[q]) polQ[q] <= wdata;
        if (strb.enWr[q])  enQ[q]  <= wdata;
      end
    end
    assign summary[q] = |idArr[q];
  end

  assign idArr = idIn;

  always_comb begin
    rdNext = '0;
    case (strb.rdSel)
      RD_PIN:
        for (int i = 0; i < PORTS; i++)
          if (strb.rdIdx == IDX_W'(i)) rdNext = pinSync[i];
      RD_SUMMARY: rdNext[IRQ_PORTS-1:0] = summary;
      RD_PAGE:    rdNext = pageLockQ;
      RD_POL, RD_EN, RD_ID:
        for (int i = 0; i < IRQ_PORTS; i++)
          if (strb.rdIdx == IDX_W'(i))
            rdNext = (strb.rdSel == RD_POL) ? polQ[i] :
                     (strb.rdSel == RD_EN)  ? enQ[i]  : idArr[i];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= rdNext;
  end

  assign latchOut = latchQ;
  assign polOut   = polQ;
  assign enOut    = enQ;
  assign pageLock = pageLockQ;
  assign rdata    = rdataQ;
endmodule

// File: rtl/pagedGpioRegs.sv
module pagedGpioRegs
  import gpioPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWe,
  input  logic [GP_ADDR_W-1:0]          busAddr,
  input  logic [GP_WIDTH-1:0]           busWdata,
  output logic [GP_WIDTH-1:0]           busRdata,
  input  logic [GP_PORTS*GP_WIDTH-1:0]  pinIn,
  input  logic [GP_IRQ_PORTS*GP_WIDTH-1:0] idIn,
  output logic [GP_PORTS*GP_WIDTH-1:0]  latchOut,
  output logic [GP_IRQ_PORTS*GP_WIDTH-1:0] polOut,
  output logic [GP_IRQ_PORTS*GP_WIDTH-1:0] enOut
);
  strobe_t             strb;
  logic [GP_WIDTH-1:0] pageLockQ;

  gpioCtrl u_ctrl (
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .page   (pageLockQ[GP_WIDTH-1 -: 2]),
    .strb   (strb)
  );

  gpioDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata),
    .pinIn   (pinIn),
    .idIn    (idIn),
    .latchOut(latchOut),
    .polOut  (polOut),
    .enOut   (enOut),
    .pageLock(pageLockQ),
    .rdata   (busRdata)
  );
endmodule

// File: rtl/pagedGpioRegsChk.sv
module pagedGpioRegsChk
  import gpioPkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic                             busSel,
  input logic                             busWe,
  input logic [GP_ADDR_W-1:0]             busAddr,
  input logic [GP_WIDTH-1:0]              busWdata,
  input logic [GP_WIDTH-1:0]              busRdata,
  input logic [GP_PORTS*GP_WIDTH-1:0]     latchOut,
  input logic [GP_IRQ_PORTS*GP_WIDTH-1:0] polOut,
  input logic [GP_IRQ_PORTS*GP_WIDTH-1:0] enOut,
  input logic [GP_WIDTH-1:0]              pageLock
);
  localparam logic [GP_ADDR_W-1:0] SUM_OFF  = GP_ADDR_W'(GP_PORTS);
  localparam logic [GP_ADDR_W-1:0] PAGE_OFF = GP_ADDR_W'(GP_PORTS + 1);
  localparam logic [GP_ADDR_W-1:0] WIN_OFF  = GP_ADDR_W'(GP_PORTS + 2);
  localparam logic [GP_ADDR_W-1:0] WIN_END  = GP_ADDR_W'(GP_PORTS + 2 + GP_IRQ_PORTS);

  for (genvar p = 0; p < GP_PORTS; p++) begin : g_port
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      busSel && busWe && busAddr == GP_ADDR_W'(p) && !pageLock[p]
      |=> latchOut[p*GP_WIDTH +: GP_WIDTH] == $past(busWdata)); // R2
    AST_LATCH_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
      busSel && busWe && busAddr == GP_ADDR_W'(p) && pageLock[p]
      |=> $stable(latchOut[p*GP_WIDTH +: GP_WIDTH])); // R3
  end

  AST_PAGE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWe && busAddr == PAGE_OFF |=> busRdata == $past(pageLock)); // R5
  AST_ID_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busWe && busAddr >= WIN_OFF && busAddr < WIN_END && pageLock[7:6] == PG_ID
    |=> $stable(polOut) && $stable(enOut)); // R8
  AST_PAGE0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busWe && busAddr >= WIN_OFF && busAddr < WIN_END && pageLock[7:6] == PG_OFF
    |=> $stable(polOut) && $stable(enOut)); // R9
  AST_SUMMARY_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWe && busAddr == SUM_OFF |=> busRdata[GP_WIDTH-1:GP_IRQ_PORTS] == '0); // R10
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWe && busAddr >= WIN_END |=> busRdata == '0); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWe) |=> $stable(busRdata)); // R12
endmodule

bind pagedGpioRegs pagedGpioRegsChk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .latchOut(latchOut),
  .polOut  (polOut),
  .enOut   (enOut),
  .pageLock(pageLockQ)
);

// File: tb/pagedGpioRegs_tb.sv
`timescale 1ns/1ps
module pagedGpioRegs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [47:0] pinIn = '0;
  logic [23:0] idIn = '0;
  logic [47:0] latchOut;
  logic [23:0] polOut, enOut;

  int checks = 0, fails = 0;
  logic [7:0] mLatch [6];
  logic [7:0] mPol [3];
  logic [7:0] mEn [3];
  logic [7:0] mPL;
  logic [7:0] rd;

  always #2 clk = ~clk;

  pagedGpioRegs u_dut (.*);

  function automatic logic [47:0] expLatch();
    logic [47:0] r;
    for (int i = 0; i < 6; i++) r[i*8 +: 8] = mLatch[i];
    return r;
  endfunction

  function automatic logic [23:0] flat3(input logic [7:0] a [3]);
    logic [23:0] r;
    for (int i = 0; i < 3; i++) r[i*8 +: 8] = a[i];
    return r;
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] a);
    logic [7:0] r;
    r = '0;
    if (a < 6) r = pinIn[a*8 +: 8];
    else if (a == 6) for (int i = 0; i < 3; i++) r[i] = |idIn[i*8 +: 8];
    else if (a == 7) r = mPL;
    else if (a <= 10) begin
      case (mPL[7:6])
        2'd1: r = mPol[a-8];
        2'd2: r = mEn[a-8];
        2'd3: r = idIn[(a-8)*8 +: 8];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic modelWrite(input logic [3:0] a, input logic [7:0] d);
    if (a < 6) begin
      if (!mPL[a]) mLatch[a] = d;
    end else if (a == 7) mPL = d;
    else if (a >= 8 && a <= 10) begin
      if (mPL[7:6] == 2'd1) mPol[a-8] = d;
      else if (mPL[7:6] == 2'd2) mEn[a-8] = d;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic readChk(input logic [3:0] a, input string tag);
    logic [7:0] e;
    e = expRead(a);
    busRead(a, rd);
    chk(tag, 64'(rd), 64'(e));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic outChk(input string tag);
    chk(tag, 64'(latchOut), 64'(expLatch()));
    chk(tag, 64'(polOut), 64'(flat3(mPol)));
    chk(tag, 64'(enOut), 64'(flat3(mEn)));
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] held, oldPins;
    for (int i = 0; i < 6; i++) mLatch[i] = '0;
    for (int i = 0; i < 3; i++) begin mPol[i] = '0; mEn[i] = '0; end
    mPL = '0;
    void'($urandom(32'd1234));
    idle(5);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    outChk("R1 reset outputs");
    chk("R1 reset rdata", 64'(busRdata), 64'd0);
    readChk(4'd7, "R1 page/lock reset");

    // R2 latch writes
    busWrite(4'd0, 8'hA5);
    busWrite(4'd5, 8'h3C);
    busWrite(4'd3, 8'hFF);
    outChk("R2 latch load");

    // R3 lock, then unlock
    busWrite(4'd7, 8'hC1);
    busWrite(4'd0, 8'h11);
    busWrite(4'd1, 8'h77);
    chk("R3 locked port0 kept", 64'(latchOut[7:0]), 64'hA5);
    chk("R3 unlocked port1 loads", 64'(latchOut[15:8]), 64'h77);
    busWrite(4'd7, 8'hC0);
    busWrite(4'd0, 8'h22);
    chk("R3 unlock restores write", 64'(latchOut[7:0]), 64'h22);

    // R4 pin read with synchronizer latency
    pinIn = 48'h0123_4567_89AB;
    idle(3);
    for (int p = 0; p < 6; p++) readChk(4'(p), "R4 pin read");
    @(negedge clk);
    oldPins = pinIn[15:8];
    pinIn[15:8] = 8'h5A;
    busRead(4'd1, rd);
    chk("R4 sync latency old value", 64'(rd), 64'(oldPins));
    busRead(4'd1, rd);
    chk("R4 sync new value", 64'(rd), 64'h5A);

    // R5 page/lock readback
    busWrite(4'd7, 8'h6A);
    readChk(4'd7, "R5 page/lock readback");
    busWrite(4'd7, 8'h40);

    // R6 polarity page
    busWrite(4'd8, 8'h12); busWrite(4'd9, 8'h34); busWrite(4'd10, 8'h56);
    outChk("R6 polarity regs");
    for (int a = 8; a <= 10; a++) readChk(4'(a), "R6 polarity read");

    // R7 enable page
    busWrite(4'd7, 8'h80);
    busWrite(4'd8, 8'hE1); busWrite(4'd9, 8'hE2); busWrite(4'd10, 8'hE3);
    outChk("R7 enable regs");
    for (int a = 8; a <= 10; a++) readChk(4'(a), "R7 enable read");

    // R8 id page read-only
    busWrite(4'd7, 8'hC0);
    idIn = 24'h80_00_05;
    idle(1);
    for (int a = 8; a <= 10; a++) readChk(4'(a), "R8 id read");
    busWrite(4'd9, 8'hFF);
    outChk("R8 id write ignored");

    // R10 summary
    readChk(4'd6, "R10 summary");
    idIn = 24'h00_10_00;
    readChk(4'd6, "R10 summary middle port");

    // R9 page 0 window
    busWrite(4'd7, 8'h00);
    busWrite(4'd9, 8'h99);
    outChk("R9 page0 write ignored");
    for (int a = 8; a <= 10; a++) readChk(4'(a), "R9 page0 reads zero");

    // R11 out of range
    for (int a = 11; a <= 15; a++) begin
      busWrite(4'(a), 8'hFF);
      readChk(4'(a), "R11 out of range read");
    end
    outChk("R11 out of range write ignored");

    // R12 hold when idle
    busRead(4'd2, held);
    pinIn = ~pinIn;
    idle(5);
    chk("R12 rdata held", 64'(busRdata), 64'(held));

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      int op;
      op = $urandom_range(0, 9);
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      if (op == 0) begin
        pinIn = {$urandom, 16'($urandom)};
        idIn = 24'($urandom) & 24'h810204;
        idle(3);
      end else if (op < 5) begin
        busWrite(a, d);
        outChk("R2 R3 R6 R7 random write");
      end else begin
        readChk(a, "R4 R5 R8 R10 random read");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule